// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Channel

This block moves a block of 36-bit words between a peripheral and core memory while the processor keeps running. Software starts a transfer with one command that carries a single 36-bit setup word and a direction bit. The upper half of the setup word is the first memory address and the lower half is how many words to move. The channel then talks to the peripheral through a valid/ready pair in each direction and keeps one word in a holding register.

Memory is shared with the processor. The channel may open a memory cycle only when the processor signals the end of an instruction, and it opens at most one cycle per such boundary. A cycle is one request held until a single acknowledge. When the last word has gone through, the channel reports completion. A build-time parameter picks one of two ways to report it: a one-cycle request to a priority interrupt channel, or a sticky program flag that software clears.

Top module: `steal_chan`

## Requirements
- R1: A command accepted while idle loads the start address from setup bits 35:18 and the word count from setup bits 17:0.
- R2: With `cmd_to_mem` = 1 the words flow from the device to memory and every stolen cycle has `mem_we` = 1. With `cmd_to_mem` = 0 they flow from memory to the device and `mem_we` = 0.
- R3: `mem_req` rises only on the clock edge at which `insn_boundary` is sampled high.
- R4: A stolen cycle holds `mem_req` and `mem_addr` steady until `mem_ack`, and drops `mem_req` on the next edge. Another cycle needs a fresh boundary.
- R5: Each acknowledge advances the address by one, modulo 2^18, and lowers the count by one. A transfer makes exactly as many memory accesses as its count.
- R6: A count of zero finishes without any memory request, and completion is signalled two edges after the command edge.
- R7: With `USE_BREAK` = 0, completion sets `prog_flag`. The flag stays set until `flag_clr`, and if completion and `flag_clr` fall in the same cycle, the completion wins. `brk_req` stays 0.
- R8: With `USE_BREAK` = 1, each completion gives a `brk_req` pulse exactly one cycle wide, and `prog_flag` stays 0.
- R9: A command presented while `busy` is high is ignored. The running transfer keeps its address, count and direction.
- R10: In device-to-memory mode, words accepted on `dev_in_valid`&`dev_in_ready` are written in order. In memory-to-device mode, words read are offered in order on `dev_out_data`, with `dev_out_valid` held until `dev_out_ready`.
- R11: `busy` is 0 out of reset, rises on the command edge, and falls on the same edge that signals completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Start command strobe |
| cmd_to_mem | input | 1 | 1: device to memory, 0: memory to device |
| cmd_setup | input | 36 | Start address (35:18) and word count (17:0) |
| insn_boundary | input | 1 | End of a processor instruction |
| dev_in_valid | input | 1 | Device offers a word |
| dev_in_data | input | 36 | Word from the device |
| dev_in_ready | output | 1 | Channel can take a device word |
| dev_out_valid | output | 1 | Channel offers a word to the device |
| dev_out_data | output | 36 | Word to the device |
| dev_out_ready | input | 1 | Device takes the offered word |
| mem_req | output | 1 | Stolen memory cycle request |
| mem_we | output | 1 | Write cycle when 1 |
| mem_addr | output | 18 | Memory address |
| mem_wdata | output | 36 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge ending the memory cycle |
| mem_rdata | input | 36 | Read data, valid with mem_ack |
| flag_clr | input | 1 | Clears the program flag |
| busy | output | 1 | Transfer in progress |
| brk_req | output | 1 | Completion pulse to the interrupt chain |
| prog_flag | output | 1 | Sticky completion flag |

## Verification
Two pairs of events can land in the same cycle. The first pair is completion and the software clear of the flag. A zero-count command is issued while the flag is already set, and `flag_clr` is driven in exactly the cycle the completion registers. The flag must still read 1 afterwards and must read 0 after a lone clear. The second pair is a new command and a running transfer. A second setup word with a different address and the opposite direction is pushed in the cycle after a transfer starts. The memory model then checks that every address and write-enable of the remaining stolen cycles still follows the first command.

// File: rtl/steal_pkg.sv
package steal_pkg;
  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_WAIT = 2'd1,
    CH_MEM  = 2'd2
  } ch_state_t;
endpackage

// File: rtl/steal_ptr.sv
module steal_ptr #(
  parameter int HALF_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [HALF_W-1:0] ld_addr,
  input  logic [HALF_W-1:0] ld_cnt,
  output logic [HALF_W-1:0] addr,
  output logic              cnt_zero
);
  logic [HALF_W-1:0] addr_q, addr_d, cnt_q, cnt_d;

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    if (load) begin
      addr_d = ld_addr;
      cnt_d  = ld_cnt;
    end else if (step) begin
      addr_d = addr_q + HALF_W'(1);
      cnt_d  = cnt_q - HALF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (load || step) begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign addr     = addr_q;
  assign cnt_zero = (cnt_q == '0);

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !cnt_zero);
endmodule

// File: rtl/steal_buf.sv
module steal_buf #(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              fill,
  input  logic [WORD_W-1:0] fill_data,
  input  logic              drain,
  output logic              full,
  output logic [WORD_W-1:0] data
);
  logic              full_q, full_d;
  logic [WORD_W-1:0] data_q;

  always_comb begin
    full_d = full_q;
    if (clr)        full_d = 1'b0;
    else if (fill)  full_d = 1'b1;
    else if (drain) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (fill) data_q <= fill_data;
  end

  assign full = full_q;
  assign data = data_q;

  // R10
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill |-> !full_q);
  // R10
  no_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain |-> full_q);
endmodule

// File: rtl/steal_done.sv
module steal_done #(
  parameter bit USE_BREAK = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic done_evt,
  input  logic flag_clr,
  output logic brk_req,
  output logic prog_flag
);
  generate
    if (USE_BREAK) begin : g_brk
      logic brk_q;
      logic clr_unused;
      assign clr_unused = flag_clr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) brk_q <= 1'b0;
        else        brk_q <= done_evt;
      end
      assign brk_req   = brk_q;
      assign prog_flag = 1'b0;

      // R8
      brk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_q |=> !brk_q);
    end else begin : g_flag
      logic flag_q, flag_d;
      always_comb flag_d = done_evt | (flag_q & ~flag_clr);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
      end
      assign prog_flag = flag_q;
      assign brk_req   = 1'b0;

      // R7
      flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q && !flag_clr |=> flag_q);
      // R7
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> flag_q);
    end
  endgenerate
endmodule

// File: rtl/steal_chan.sv
module steal_chan
  import steal_pkg::*;
#(
  parameter int WORD_W    = 36,
  parameter bit USE_BREAK = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic                cmd_to_mem,
  input  logic [WORD_W-1:0]   cmd_setup,
  input  logic                insn_boundary,
  input  logic                dev_in_valid,
  input  logic [WORD_W-1:0]   dev_in_data,
  output logic                dev_in_ready,
  output logic                dev_out_valid,
  output logic [WORD_W-1:0]   dev_out_data,
  input  logic                dev_out_ready,
  output logic                mem_req,
  output logic                mem_we,
  output logic [WORD_W/2-1:0] mem_addr,
  output logic [WORD_W-1:0]   mem_wdata,
  input  logic                mem_ack,
  input  logic [WORD_W-1:0]   mem_rdata,
  input  logic                flag_clr,
  output logic                busy,
  output logic                brk_req,
  output logic                prog_flag
);
  localparam int HALF_W = WORD_W / 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  ch_state_t         st_q, st_d;
  logic              dir_q;
  logic              load, steal_go, done_evt, step;
  logic              cnt_zero, buf_full, fill, drain;
  logic [WORD_W-1:0] buf_data, fill_data;
  logic [HALF_W-1:0] addr;

  assign load     = (st_q == CH_IDLE) && cmd_valid;
  assign steal_go = (st_q == CH_WAIT) && insn_boundary && !cnt_zero &&
                    (dir_q ? buf_full : !buf_full);
  assign done_evt = (st_q == CH_WAIT) && cnt_zero && !buf_full;
  assign step     = (st_q == CH_MEM) && mem_ack;

  always_comb begin
    st_d = st_q;
    case (st_q)
      CH_IDLE: if (cmd_valid) st_d = CH_WAIT;
      CH_WAIT: begin
        if (done_evt)      st_d = CH_IDLE;
        else if (steal_go) st_d = CH_MEM;
      end
      CH_MEM:  if (mem_ack) st_d = CH_WAIT;
      default: st_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) st_q <= CH_IDLE;
    else          st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)  dir_q <= 1'b0;
    else if (load) dir_q <= cmd_to_mem;
  end

  assign dev_in_ready  = (st_q == CH_WAIT) && dir_q && !buf_full && !cnt_zero;
  assign dev_out_valid = !dir_q && buf_full;
  assign dev_out_data  = buf_data;

  assign fill      = (dev_in_valid && dev_in_ready) || (step && !dir_q);
  assign fill_data = dir_q ? dev_in_data : mem_rdata;
  assign drain     = (dev_out_valid && dev_out_ready) || (step && dir_q);

  steal_ptr #(.HALF_W(HALF_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .load     (load),
    .step     (step),
    .ld_addr  (cmd_setup[WORD_W-1:HALF_W]),
    .ld_cnt   (cmd_setup[HALF_W-1:0]),
    .addr     (addr),
    .cnt_zero (cnt_zero)
  );

  steal_buf #(.WORD_W(WORD_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .clr       (load),
    .fill      (fill),
    .fill_data (fill_data),
    .drain     (drain),
    .full      (buf_full),
    .data      (buf_data)
  );

  steal_done #(.USE_BREAK(USE_BREAK)) u_done (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .done_evt  (done_evt),
    .flag_clr  (flag_clr),
    .brk_req   (brk_req),
    .prog_flag (prog_flag)
  );

  assign mem_req   = (st_q == CH_MEM);
  assign mem_we    = (st_q == CH_MEM) && dir_q;
  assign mem_addr  = addr;
  assign mem_wdata = buf_data;
  assign busy      = (st_q != CH_IDLE);

  // R3
  steal_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(mem_req) |-> $past(insn_boundary));
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  // R4
  one_steal_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_req && mem_ack |=> !mem_req);
  // R9
  busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    busy && cmd_valid && !mem_req |=> $stable(mem_addr) && busy);
endmodule

// File: tb/steal_chan_bench.sv
module steal_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_to_mem, insn_boundary;
  logic [35:0] cmd_setup;
  logic        dev_in_valid, dev_out_ready, mem_ack, flag_clr;
  logic [35:0] dev_in_data, mem_rdata;
  logic        dev_in_ready, dev_out_valid, mem_req, mem_we, busy, brk_req, prog_flag;
  logic [35:0] dev_out_data, mem_wdata;
  logic [17:0] mem_addr;
  logic        b_in_ready, b_out_valid, b_req, b_we, b_busy, b_brk, b_flag;
  logic [35:0] b_out_data, b_wdata;
  logic [17:0] b_addr;

  always #4 clk = ~clk;

  steal_chan u_steal_chan (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_to_mem(cmd_to_mem),
    .cmd_setup(cmd_setup), .insn_boundary(insn_boundary),
    .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
    .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .flag_clr(flag_clr),
    .busy(busy), .brk_req(brk_req), .prog_flag(prog_flag));

  steal_chan #(.USE_BREAK(1'b1)) u_steal_chan_brk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_to_mem(cmd_to_mem),
    .cmd_setup(cmd_setup), .insn_boundary(insn_boundary),
    .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_ready(b_in_ready),
    .dev_out_valid(b_out_valid), .dev_out_data(b_out_data), .dev_out_ready(dev_out_ready),
    .mem_req(b_req), .mem_we(b_we), .mem_addr(b_addr), .mem_wdata(b_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .flag_clr(flag_clr),
    .busy(b_busy), .brk_req(b_brk), .prog_flag(b_flag));

  int unsigned total = 0, fails = 0, cyc = 0;
  int unsigned acc_cnt = 0, req_seen = 0, brk_cnt = 0, n_done = 0, wait_left = 0;
  logic [17:0] exp_addr = '0;
  logic        exp_we = 1'b0, bnd_q = 1'b0, req_prev = 1'b0, brk_prev = 1'b0, bflag_seen = 1'b0;
  logic [35:0] mem_model [0:255];
  logic [35:0] wr_words [0:63];

  function automatic logic [35:0] rd_fn(input logic [17:0] a);
    return {a, a ^ 18'h15555};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bnd_q <= insn_boundary;
    cyc++;
    if (cyc == 150000) begin
      chk(1'b0, "WATCHDOG", "run did not end", 64'(cyc), 64'd0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  // memory model and per-access checks
  always @(negedge clk) begin
    if (rst_n) begin
      if (b_brk) brk_cnt++;
      if (b_brk && brk_prev) chk(1'b0, "R8", "brk pulse wider than one cycle", 1, 0);
      brk_prev = b_brk;
      if (b_flag) bflag_seen = 1'b1;
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (!req_prev) begin
          req_seen++;
          chk(bnd_q == 1'b1, "R3", "request without boundary", 64'(bnd_q), 1);
          chk(mem_addr == exp_addr, "R5", "access address", 64'(mem_addr), 64'(exp_addr));
          chk(mem_we == exp_we, "R2", "write enable vs direction", 64'(mem_we), 64'(exp_we));
          wait_left = $urandom % 3;
        end
        if (wait_left == 0) begin
          mem_ack = 1'b1;
          if (mem_we) mem_model[mem_addr[7:0]] = mem_wdata;
          else        mem_rdata = rd_fn(mem_addr);
          acc_cnt++;
          exp_addr = exp_addr + 18'd1;
        end else wait_left--;
      end
      req_prev = mem_req;
    end
  end

  task automatic run_xfer(input bit dir, input logic [17:0] start, input logic [17:0] cnt,
                          input int unsigned bnd_pct, input int unsigned stall_pct, input bit poke);
    int unsigned sent = 0, got = 0, mism = 0;
    bit done = 0;
    exp_addr = start; exp_we = dir; acc_cnt = 0;
    for (int i = 0; i < 64; i++) wr_words[i] = {$urandom, 4'($urandom)};
    @(negedge clk);
    cmd_valid = 1'b1; cmd_to_mem = dir; cmd_setup = {start, cnt};
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R11", "busy after command", 64'(busy), 1);
    if (poke) begin // R9: second command while busy
      cmd_valid = 1'b1; cmd_to_mem = ~dir; cmd_setup = {start + 18'd100, 18'd7};
    end
    for (int k = 0; k < 4000; k++) begin
      if (k == 1) cmd_valid = 1'b0;
      if (!busy) begin done = 1; break; end
      insn_boundary = ($urandom % 100) < bnd_pct;
      if (dir) begin
        dev_in_valid = (sent < cnt) && (($urandom % 100) >= stall_pct);
        dev_in_data  = wr_words[sent % 64];
        if (dev_in_valid && dev_in_ready) sent++;
      end else begin
        dev_out_ready = ($urandom % 100) >= stall_pct;
        if (dev_out_valid && dev_out_ready) begin
          if (dev_out_data != rd_fn(start + 18'(got))) mism++;
          got++;
        end
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0; insn_boundary = 1'b0; dev_in_valid = 1'b0; dev_out_ready = 1'b0;
    n_done++;
    chk(done == 1, "R11", "busy fell at completion", 64'(busy), 0);
    chk(prog_flag == 1'b1, "R7", "flag set with completion edge", 64'(prog_flag), 1);
    chk(acc_cnt == 32'(cnt), "R5", "number of accesses", 64'(acc_cnt), 64'(cnt));
    if (dir) begin
      for (int i = 0; i < 32'(cnt); i++) begin
        logic [17:0] a;
        a = start + 18'(i);
        if (mem_model[a[7:0]] != wr_words[i]) mism++;
      end
      chk(mism == 0, "R10", "written words", 64'(mism), 0);
    end else begin
      chk(got == 32'(cnt) && mism == 0, "R10", "read words delivered", 64'(got), 64'(cnt));
    end
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk(prog_flag == 1'b0, "R7", "flag cleared", 64'(prog_flag), 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_C0DE));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_to_mem = 1'b0; cmd_setup = '0;
    insn_boundary = 1'b0; dev_in_valid = 1'b0; dev_in_data = '0; dev_out_ready = 1'b0;
    mem_ack = 1'b0; mem_rdata = '0; flag_clr = 1'b0;
    for (int i = 0; i < 256; i++) mem_model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !mem_req && !prog_flag && !dev_in_ready && !dev_out_valid && !brk_req,
        "R11", "reset state", {busy, mem_req, prog_flag, dev_in_ready, dev_out_valid}, 0);

    // R1 R2 R10 directed transfers, including address wrap at the top of the space
    run_xfer(1'b1, 18'h3FFFE, 18'd4, 100, 0, 0);
    run_xfer(1'b0, 18'h00010, 18'd1, 50, 30, 0);
    run_xfer(1'b0, 18'h3FFFF, 18'd3, 20, 50, 0);
    // R9 second command while busy
    run_xfer(1'b1, 18'h01200, 18'd3, 30, 20, 1);

    // R6 zero count: no request, completion two edges after command
    begin
      int unsigned rs;
      rs = req_seen;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_to_mem = 1'b1; cmd_setup = {18'h00abc, 18'd0};
      insn_boundary = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(prog_flag == 1'b0 && busy, "R6", "not done one edge after command", 64'(prog_flag), 0);
      @(negedge clk);
      chk(prog_flag == 1'b1 && !busy, "R6", "done two edges after command", 64'(prog_flag), 1);
      chk(b_brk == 1'b1 && b_flag == 1'b0, "R8", "break pulse present", 64'(b_brk), 1);
      @(negedge clk);
      insn_boundary = 1'b0;
      chk(b_brk == 1'b0, "R8", "break pulse ended", 64'(b_brk), 0);
      chk(req_seen == rs, "R6", "no memory request", 64'(req_seen), 64'(rs));
      n_done++;
      // R7 completion and clear in the same cycle: set wins
      cmd_valid = 1'b1; cmd_setup = {18'h00abc, 18'd0};
      @(negedge clk);
      cmd_valid = 1'b0; flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      chk(prog_flag == 1'b1, "R7", "set wins over same-cycle clear", 64'(prog_flag), 1);
      n_done++;
      repeat (5) @(negedge clk);
      chk(prog_flag == 1'b1, "R7", "flag held", 64'(prog_flag), 1);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      chk(prog_flag == 1'b0, "R7", "lone clear", 64'(prog_flag), 0);
    end

    // random transfers
    for (int t = 0; t < 12; t++) begin
      int unsigned bp;
      bp = (t % 3 == 0) ? 100 : ((t % 3 == 1) ? 50 : 15);
      run_xfer(1'($urandom), 18'($urandom), 18'(1 + $urandom % 24), bp, $urandom % 60, (t % 4) == 3);
    end

    repeat (3) @(negedge clk);
    chk(brk_cnt == n_done, "R8", "break pulses per completion", 64'(brk_cnt), 64'(n_done));
    chk(bflag_seen == 1'b0 && brk_req == 1'b0, "R8", "break variant never sets flag", 64'(bflag_seen), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule